// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block decides whether the local interrupt controller of one processor is among the targets of an inter-processor interrupt. It takes the destination description carried with the message (shorthand, physical or logical mode, destination field, and whether the sender is this very processor) together with the local identity state (ID register, programmed logical register and the destination-format register). It answers with one match bit.

Two addressing schemes are covered. Legacy mode uses an 8-bit ID and an 8-bit logical ID, with the format register choosing between a flat bitmask model and a cluster model. Extended mode uses a 32-bit logical register that is not programmed but derived from the physical ID, and ignores the format register. The block holds the format register itself, exposes the derived extended logical register, and registers both results, so an answer appears one clock after its inputs.

Top module: `idm_dest_matcher`

## Requirements
- R1: With shorthand code 1 (self), the match is set exactly when `src_is_self` is 1.
- R2: With shorthand code 2 (all including self), the match is always set.
- R3: With shorthand code 3 (all but self), the match is set exactly when `src_is_self` is 0.
- R4: With shorthand code 0 and `dest_logical`=0, a destination whose bits 7:0 equal 0xFF matches in either addressing mode.
- R5: With shorthand code 0 and `dest_logical`=0, any other destination matches only when `dest[7:0]` equals `local_id[31:24]`.
- R6: In legacy mode (`ext_mode`=0) with `dest_logical`=1 and format bits 31:28 equal to 0xF (flat), the match is set when `ldr_prog[31:24] & dest[7:0]` is nonzero.
- R7: In legacy logical addressing with format bits 31:28 equal to 0x0 (cluster), the match needs `ldr_prog[31:28]==dest[7:4]` and a nonzero AND of `ldr_prog[27:24]` with `dest[3:0]`.
- R8: In legacy logical addressing with format bits 31:28 neither 0xF nor 0x0, no match results.
- R9: In extended mode (`ext_mode`=1) logical addressing matches when the derived logical register ANDed with the 32-bit `dest` is nonzero; the format register has no effect.
- R10: `ldr_ext_o` equals `((id & 0xF0) << 16) | (1 << (id & 0xF))` with id = `local_id[31:24]`.
- R11: The format register resets to 0xFFFFFFFF; a write stores the written value with bits 27:0 forced to one; without a write it holds its value. It is visible on `fmt_o`.
- R12: `match_o` and `ldr_ext_o` are registered: each reflects the inputs present at the previous rising clock edge and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects extended 32-bit addressing |
| shorthand | input | 2 | 0 none, 1 self, 2 all incl. self, 3 all but self |
| dest_logical | input | 1 | 1 logical destination, 0 physical |
| dest | input | 32 | Destination field |
| src_is_self | input | 1 | Sender is this processor |
| local_id | input | 32 | ID register, 8-bit ID in bits 31:24 |
| ldr_prog | input | 32 | Programmed logical register, logical ID in bits 31:24 |
| fmt_wr_en | input | 1 | Format register write strobe |
| fmt_wr_data | input | 32 | Format register write value |
| match_o | output | 1 | Registered match result |
| ldr_ext_o | output | 32 | Registered derived extended logical register |
| fmt_o | output | 32 | Current format register |

## Verification
Directed patterns first separate each shorthand with the self flag both ways, then the physical broadcast from an exact ID hit and a one-off miss. Logical patterns vary the format model across flat, cluster and an undefined code, choosing IDs where flat and cluster disagree (same bits, different cluster nibble), and in extended mode pick a format that would reject in legacy to show it is ignored. A long random stream then mixes all fields, including format writes in the same cycle as a match, which tells whether the match uses the format before or after the write.

// File: rtl/idm_pkg.sv
package idm_pkg;
    typedef enum logic [1:0] {
        SH_NONE    = 2'd0,
        SH_SELF    = 2'd1,
        SH_ALL_INC = 2'd2,
        SH_ALL_EXC = 2'd3
    } idm_short_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
endpackage

// File: rtl/idm_phys_cmp.sv
module idm_phys_cmp #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest_id,
    input  logic [ID_W-1:0] own_id,
    output logic            hit
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    always_comb begin
        hit = (dest_id == BCAST) || (dest_id == own_id);
    end
endmodule

// File: rtl/idm_logic_cmp.sv
module idm_logic_cmp #(
    parameter int ID_W = 8
) (
    input  logic [3:0]      model,
    input  logic [ID_W-1:0] lid,
    input  logic [ID_W-1:0] mda,
    output logic            hit
);
    import idm_pkg::*;
    localparam int HALF = ID_W / 2;

    logic flat_hit;
    logic clus_hit;

    always_comb begin
        flat_hit = |(lid & mda);
        clus_hit = (lid[ID_W-1:HALF] == mda[ID_W-1:HALF]) &&
                   (|(lid[HALF-1:0] & mda[HALF-1:0]));
        case (model)
            MODEL_FLAT:    hit = flat_hit;
            MODEL_CLUSTER: hit = clus_hit;
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/idm_ext_ldr.sv
module idm_ext_ldr #(
    parameter int ID_W  = 8,
    parameter int REG_W = 32
) (
    input  logic [ID_W-1:0]  id,
    output logic [REG_W-1:0] ldr
);
    localparam int LOW_W   = 4;
    localparam int N_SLOTS = 1 << LOW_W;
    localparam int SHIFT   = 16;

    logic [REG_W-1:0] cluster_part;
    logic [REG_W-1:0] onehot_part;

    always_comb begin
        cluster_part = '0;
        cluster_part[SHIFT +: ID_W] = {id[ID_W-1:LOW_W], {LOW_W{1'b0}}};
        onehot_part = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            onehot_part[i] = (id[LOW_W-1:0] == LOW_W'(i));
        end
        ldr = cluster_part | onehot_part;
    end
endmodule

// File: rtl/idm_dest_matcher.sv
module idm_dest_matcher #(
    parameter int REG_W = 32,
    parameter int ID_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic [1:0]       shorthand,
    input  logic             dest_logical,
    input  logic [REG_W-1:0] dest,
    input  logic             src_is_self,
    input  logic [REG_W-1:0] local_id,
    input  logic [REG_W-1:0] ldr_prog,
    input  logic             fmt_wr_en,
    input  logic [REG_W-1:0] fmt_wr_data,
    output logic             match_o,
    output logic [REG_W-1:0] ldr_ext_o,
    output logic [REG_W-1:0] fmt_o
);
    import idm_pkg::*;

    localparam int               ID_LSB    = REG_W - ID_W;
    localparam int               MODEL_LSB = REG_W - 4;
    localparam logic [REG_W-1:0] LOW_ONES  = {4'b0, {(REG_W-4){1'b1}}};

    typedef struct packed {
        logic             match;
        logic [REG_W-1:0] ldr_ext;
        logic [REG_W-1:0] fmt;
    } state_t;

    state_t state_d, state_q;

    logic [ID_W-1:0]  own_id;
    logic [REG_W-1:0] ldr_ext;
    logic             phys_hit;
    logic             leg_hit;
    idm_short_e       sh;

    assign own_id = local_id[REG_W-1:ID_LSB];
    assign sh     = idm_short_e'(shorthand);

    idm_phys_cmp #(.ID_W(ID_W)) u_phys (
        .dest_id (dest[ID_W-1:0]),
        .own_id  (own_id),
        .hit     (phys_hit)
    );

    idm_logic_cmp #(.ID_W(ID_W)) u_logic (
        .model (state_q.fmt[REG_W-1:MODEL_LSB]),
        .lid   (ldr_prog[REG_W-1:ID_LSB]),
        .mda   (dest[ID_W-1:0]),
        .hit   (leg_hit)
    );

    idm_ext_ldr #(.ID_W(ID_W), .REG_W(REG_W)) u_ext (
        .id  (own_id),
        .ldr (ldr_ext)
    );

    always_comb begin
        state_d = state_q;
        state_d.ldr_ext = ldr_ext;
        case (sh)
            SH_SELF:    state_d.match = src_is_self;
            SH_ALL_INC: state_d.match = 1'b1;
            SH_ALL_EXC: state_d.match = !src_is_self;
            default: begin
                if (!dest_logical)
                    state_d.match = phys_hit;
                else if (ext_mode)
                    state_d.match = |(ldr_ext & dest);
                else
                    state_d.match = leg_hit;
            end
        endcase
        if (fmt_wr_en)
            state_d.fmt = fmt_wr_data | LOW_ONES;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.match   <= 1'b0;
            state_q.ldr_ext <= '0;
            state_q.fmt     <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign match_o   = state_q.match;
    assign ldr_ext_o = state_q.ldr_ext;
    assign fmt_o     = state_q.fmt;

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == 2'd1 && !src_is_self) |=> !match_o); // R1
    AST_ALL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == 2'd2) |=> match_o); // R2
    AST_ALL_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == 2'd3 && src_is_self) |=> !match_o); // R3
    AST_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == 2'd0 && !dest_logical && dest[ID_W-1:0] == {ID_W{1'b1}}) |=> match_o); // R4
    AST_BAD_MODEL: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == 2'd0 && dest_logical && !ext_mode &&
         fmt_o[REG_W-1:MODEL_LSB] != 4'hF && fmt_o[REG_W-1:MODEL_LSB] != 4'h0) |=> !match_o); // R8
    AST_LDR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(ldr_ext_o[15:0]) == 1); // R10
    AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_wr_en |=> $stable(fmt_o)); // R11
endmodule

// File: tb/idm_dest_matcher_tb.sv
module idm_dest_matcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [1:0]  shorthand = 2'd0;
    logic        dest_logical = 1'b0;
    logic [31:0] dest = 32'd0;
    logic        src_is_self = 1'b0;
    logic [31:0] local_id = 32'd0;
    logic [31:0] ldr_prog = 32'd0;
    logic        fmt_wr_en = 1'b0;
    logic [31:0] fmt_wr_data = 32'd0;
    logic        match_o;
    logic [31:0] ldr_ext_o;
    logic [31:0] fmt_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] fmt_m;
    bit          exp_match;
    logic [31:0] exp_ldr;
    string       exp_tag;

    always #5 clk = ~clk;

    idm_dest_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .shorthand(shorthand),
        .dest_logical(dest_logical), .dest(dest), .src_is_self(src_is_self),
        .local_id(local_id), .ldr_prog(ldr_prog), .fmt_wr_en(fmt_wr_en),
        .fmt_wr_data(fmt_wr_data), .match_o(match_o), .ldr_ext_o(ldr_ext_o),
        .fmt_o(fmt_o)
    );

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_ldr(logic [31:0] idr);
        int idv = int'(idr[31:24]);
        return 32'((idv & 'hF0) << 16) | (32'd1 << (idv & 15));
    endfunction

    // behavioural reference; fills exp_match / exp_tag
    task automatic ref_eval();
        int lid = int'(ldr_prog[31:24]);
        int mda = int'(dest[7:0]);
        int mdl = int'(fmt_m[31:28]);
        exp_ldr = ref_ldr(local_id);
        if (shorthand == 2'd1) begin exp_match = src_is_self; exp_tag = "R1"; end
        else if (shorthand == 2'd2) begin exp_match = 1; exp_tag = "R2"; end
        else if (shorthand == 2'd3) begin exp_match = !src_is_self; exp_tag = "R3"; end
        else if (!dest_logical) begin
            if (mda == 255) begin exp_match = 1; exp_tag = "R4"; end
            else begin exp_match = (mda == int'(local_id[31:24])); exp_tag = "R5"; end
        end else if (ext_mode) begin
            exp_match = ((exp_ldr & dest) != 0); exp_tag = "R9";
        end else if (mdl == 15) begin
            exp_match = ((lid & mda) != 0); exp_tag = "R6";
        end else if (mdl == 0) begin
            exp_match = ((lid / 16) == (mda / 16)) && (((lid % 16) & (mda % 16)) != 0);
            exp_tag = "R7";
        end else begin exp_match = 0; exp_tag = "R8"; end
    endtask

    // called at a negedge: drive, predict, wait one cycle, compare
    task automatic apply(bit ext, logic [1:0] sh, bit lg, logic [31:0] d, bit self,
                         logic [31:0] idr, logic [31:0] ldr, bit we, logic [31:0] wd);
        ext_mode = ext; shorthand = sh; dest_logical = lg; dest = d;
        src_is_self = self; local_id = idr; ldr_prog = ldr;
        fmt_wr_en = we; fmt_wr_data = wd;
        ref_eval();
        if (we) fmt_m = wd | 32'h0FFF_FFFF;
        @(negedge clk);
        check({exp_tag, " match"}, match_o, exp_match);
        check("R10 ldr_ext", ldr_ext_o, exp_ldr);
        check("R11 fmt", fmt_o, fmt_m);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        fmt_m = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R12 reset match", match_o, 0);
        check("R12 reset ldr", ldr_ext_o, 0);
        check("R11 reset fmt", fmt_o, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        // shorthands
        apply(0, 2'd1, 0, 32'h12, 1, 32'h0500_0000, 0, 0, 0);
        apply(0, 2'd1, 0, 32'h05, 0, 32'h0500_0000, 0, 0, 0);
        apply(0, 2'd2, 0, 32'h00, 0, 32'h0500_0000, 0, 0, 0);
        apply(0, 2'd3, 0, 32'h05, 1, 32'h0500_0000, 0, 0, 0);
        apply(0, 2'd3, 0, 32'h00, 0, 32'h0500_0000, 0, 0, 0);
        // physical
        apply(0, 2'd0, 0, 32'hFF, 0, 32'h0500_0000, 0, 0, 0);
        apply(1, 2'd0, 0, 32'hFF, 0, 32'h0500_0000, 0, 0, 0);
        apply(0, 2'd0, 0, 32'h05, 0, 32'h0500_0000, 0, 0, 0);
        apply(0, 2'd0, 0, 32'h04, 0, 32'h0500_0000, 0, 0, 0);
        // flat (reset format)
        apply(0, 2'd0, 1, 32'h21, 0, 0, 32'h2100_0000, 0, 0);
        apply(0, 2'd0, 1, 32'h12, 0, 0, 32'h2100_0000, 0, 0);
        // switch to cluster: write in same cycle still uses old model (flat)
        apply(0, 2'd0, 1, 32'h31, 0, 0, 32'h2100_0000, 1, 32'h0000_0000);
        apply(0, 2'd0, 1, 32'h31, 0, 0, 32'h2100_0000, 0, 0);
        apply(0, 2'd0, 1, 32'h23, 0, 0, 32'h2100_0000, 0, 0);
        apply(0, 2'd0, 1, 32'h22, 0, 0, 32'h2100_0000, 0, 0);
        // undefined model
        apply(0, 2'd0, 1, 32'h23, 0, 0, 32'h2100_0000, 1, 32'h5123_4567);
        apply(0, 2'd0, 1, 32'hFF, 0, 0, 32'hFF00_0000, 0, 0);
        // extended: format ignored
        apply(1, 2'd0, 1, 32'h0030_0000, 0, 32'h3700_0000, 0, 0, 0);
        apply(1, 2'd0, 1, 32'h0000_0080, 0, 32'h3700_0000, 0, 0, 0);
        apply(1, 2'd0, 1, 32'h0000_0040, 0, 32'h3700_0000, 0, 0, 0);
        apply(1, 2'd0, 1, 32'h0000_8000, 0, 32'hAF00_0000, 0, 0, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] ld = {4'($urandom_range(0, 3)), 4'($urandom), 24'h0};
            logic [31:0] wd = {(r[3] ? 4'hF : (r[4] ? 4'h0 : 4'($urandom))), 28'($urandom)};
            logic [31:0] d = r[5] ? 32'($urandom) : {24'h0, 4'($urandom_range(0, 3)), 4'($urandom)};
            apply(r[0], 2'(r[2:1] & {r[6], r[7]}), r[8], d, r[9],
                  {4'($urandom_range(0, 3)), 4'($urandom), 24'($urandom)}, ld,
                  (r[12:10] == 3'd0), wd);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule